// File: doc/BRIEF.md
# Dual-Timing Multiplexed Host Bus Port

This block sits between a host processor and a 128-byte register file. The host reaches the register file over an 8-bit bus that carries the address first and the data afterwards. The low 14 bytes of the space are clock and control registers and the remaining 114 bytes are general storage. A static strap picks one of two host timing styles:

- **Split-strobe style:** separate read and write strobes, both active low.
- **Combined-strobe style:** one data strobe plus a direction level.

All host pins are sampled on the block clock. The strobes pass through two flip-flops, and their edges are found on the synchronized copies. The bus data passes through a matching two-stage pipeline so that it stays aligned with the strobes. On the register-file side the block gives:

- a latched register address;
- a flag that marks storage bytes;
- one-cycle write pulses that carry the data;
- one-cycle read pulses;
- an output enable for the bus drivers while a selected read is in progress.

Top module: `mbus_host_if`

## Requirements
- R1: While `rst_n` is low and after its release, `ad_oe`, `reg_wr` and `reg_rd` are 0 and `reg_addr` is 0 until the first address is latched.
- R2: A falling edge on `as_i` latches the bus byte as the address within 3 clock edges, whatever the level of `cs_n`; `reg_addr` changes at no other time.
- R3: In split-strobe mode (`mode_ds`=0), a rising edge of `rw_i` (write strobe, active low) while `cs_n` is low gives exactly one single-cycle `reg_wr` pulse. The pulse carries the latched address and, on `reg_wdata`, the bus byte present at that edge.
- R4: In split-strobe mode, a falling edge of `ds_i` (read strobe, active low) while `cs_n` is low gives one single-cycle `reg_rd` pulse. In the same cycle `ad_oe` rises and `ad_out` equals `reg_rdata` for the latched address. `ad_oe` returns to 0 within 3 clocks of `ds_i` going high.
- R5: In combined-strobe mode (`mode_ds`=1), `rw_i` high marks a read and `rw_i` low marks a write. A rising `ds_i` with `rw_i` high starts a read as in R4, and a falling `ds_i` ends it. A falling `ds_i` with `rw_i` low gives one write pulse as in R3.
- R6: In combined-strobe mode, `ad_oe` stays 0 while `ds_i` is low, even when a read is set up. A rising `ds_i` with `rw_i` low produces neither `reg_rd` nor `reg_wr`.
- R7: With `cs_n` high during the data phase, strobe edges produce no `reg_wr`, no `reg_rd` and no `ad_oe`.
- R8: When the latched address has bit 7 set (outside the 128-byte space), no write pulse, read pulse or output enable is produced.
- R9: `reg_store` is 0 for latched addresses 0 to 13 and 1 for addresses 14 to 127.
- R10: Strobe activity while `rst_n` is low has no effect on the register file, and no pulse appears after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; blocks all access |
| mode_ds | input | 1 | Timing strap: 0 split strobes, 1 data strobe with direction |
| cs_n | input | 1 | Chip select, active low, qualifies the data phase |
| as_i | input | 1 | Address strobe; falling edge latches the address |
| ds_i | input | 1 | Read strobe (mode 0, active low) or data strobe (mode 1) |
| rw_i | input | 1 | Write strobe (mode 0, active low) or direction, high = read (mode 1) |
| ad_in | input | 8 | Bus byte as seen at the pins |
| ad_out | output | 8 | Read byte for the bus drivers |
| ad_oe | output | 1 | Bus driver enable during a selected read |
| reg_addr | output | 7 | Latched register address |
| reg_store | output | 1 | Latched address is a storage byte |
| reg_wr | output | 1 | One-cycle write pulse |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_rd | output | 1 | One-cycle pulse at the start of a read |
| reg_rdata | input | 8 | Register file contents at `reg_addr` |

## Verification
The hardest cases to reach are two combined-strobe situations. In the first, a read is fully set up with the direction high, but the data strobe has not yet risen. In the second, the data strobe rises while the direction is low. Both are legal strobe movements that must not enable the drivers or produce a pulse. The stimulus holds the bus in each of these states for several clocks and samples `ad_oe` there, before it completes the cycle. Reset blocking is reached by running a complete selected write while reset is held and then releasing reset. Any late pulse is then caught by the scoreboard as an unexpected item.

// File: rtl/mbus_host_if.sv
module mbus_host_if #(
  parameter int DW         = 8,
  parameter int SPACE      = 128,
  parameter int CTRL_BYTES = 14,
  localparam int AW        = $clog2(SPACE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ds,
  input  logic          cs_n,
  input  logic          as_i,
  input  logic          ds_i,
  input  logic          rw_i,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-1:0] reg_addr,
  output logic          reg_store,
  output logic          reg_wr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata
);

  logic [2:0]    as_q, ds_q, rw_q;
  logic [1:0]    cs_q;
  logic [DW-1:0] ad_q1, ad_q2;
  logic [DW-1:0] addr_q;
  logic          rd_phase, rd_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q  <= '0;
      ds_q  <= {3{~mode_ds}};
      rw_q  <= '1;
      cs_q  <= '1;
      ad_q1 <= '0;
      ad_q2 <= '0;
    end else begin
      as_q  <= {as_q[1:0], as_i};
      ds_q  <= {ds_q[1:0], ds_i};
      rw_q  <= {rw_q[1:0], rw_i};
      cs_q  <= {cs_q[0], cs_n};
      ad_q1 <= ad_in;
      ad_q2 <= ad_q1;
    end
  end

  wire as_fall  = as_q[2] & ~as_q[1];
  wire ds_fall  = ds_q[2] & ~ds_q[1];
  wire ds_rise  = ~ds_q[2] & ds_q[1];
  wire rw_rise  = ~rw_q[2] & rw_q[1];
  wire sel      = ~cs_q[1];
  wire in_range = (addr_q[DW-1:AW] == '0);
  wire ok       = sel & in_range;

  wire wr_go = ok & (mode_ds ? (ds_fall & ~rw_q[1]) : rw_rise);
  wire rd_go = ok & (mode_ds ? (ds_rise & rw_q[1]) : ds_fall);
  wire rd_stop = ~sel | (mode_ds ? ~ds_q[1] : ds_q[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      rd_phase <= 1'b0;
      rd_pulse <= 1'b0;
    end else begin
      if (as_fall) addr_q <= ad_q2;
      rd_pulse <= rd_go;
      if (rd_go)        rd_phase <= 1'b1;
      else if (rd_stop) rd_phase <= 1'b0;
    end
  end

  assign reg_addr  = addr_q[AW-1:0];
  assign reg_store = (addr_q[AW-1:0] >= AW'(CTRL_BYTES));
  assign reg_wr    = wr_go;
  assign reg_wdata = ad_q2;
  assign reg_rd    = rd_pulse;
  assign ad_oe     = rd_phase;
  assign ad_out    = reg_rdata;

endmodule

module mbus_host_if_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic          ad_oe,
  input logic [AW-1:0] reg_addr,
  input logic          as_fall
);

  a_r3_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  a_r4_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  a_r4_oe_starts_with_rd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> reg_rd);

  a_r5_no_wr_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !reg_wr);

  a_r2_addr_only_on_as: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_addr) |-> $past(as_fall));

  always_comb begin
    if (!rst_n) begin
      a_r10_reset_quiet: assert (!reg_wr && !ad_oe && !reg_rd);
    end
  end

endmodule

bind mbus_host_if mbus_host_if_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .ad_oe    (ad_oe),
  .reg_addr (reg_addr),
  .as_fall  (as_fall)
);

// File: tb/mbus_host_if_tb.sv
module mbus_host_if_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_ds = 1'b0;
  logic       cs_n = 1'b1;
  logic       as_i = 1'b0;
  logic       ds_i = 1'b1;
  logic       rw_i = 1'b1;
  logic [7:0] ad_in = '0;
  logic [7:0] ad_out, reg_wdata, reg_rdata;
  logic       ad_oe, reg_store, reg_wr, reg_rd;
  logic [6:0] reg_addr;

  logic [7:0] regfile [128];
  logic [7:0] shadow  [128];

  typedef struct packed { logic is_wr; logic [6:0] addr; logic [7:0] data; } item_t;
  item_t exp_q[$];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_host_if dut_i (
    .clk(clk), .rst_n(rst_n), .mode_ds(mode_ds), .cs_n(cs_n),
    .as_i(as_i), .ds_i(ds_i), .rw_i(rw_i), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .reg_addr(reg_addr),
    .reg_store(reg_store), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = regfile[reg_addr];
  always @(posedge clk) if (reg_wr) regfile[reg_addr] <= reg_wdata;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as pulses appear
  always @(negedge clk) begin
    if (rst_n && (reg_wr || reg_rd)) begin
      if (exp_q.size() == 0) begin
        check(0, "R7/R8/R10 unexpected pulse", {reg_wr, reg_addr}, 0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (it.is_wr) begin
          check(reg_wr && !reg_rd, "R3/R5 write kind", reg_wr, 1);
          check(reg_addr == it.addr && reg_wdata == it.data, "R3/R5 write addr/data",
                {reg_addr, reg_wdata}, {it.addr, it.data});
        end else begin
          check(reg_rd && ad_oe, "R4/R5 read oe", {reg_rd, ad_oe}, 3);
          check(reg_addr == it.addr && ad_out == it.data, "R4/R5 read addr/data",
                {reg_addr, ad_out}, {it.addr, it.data});
        end
      end
    end
  end

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic addr_phase(input logic [7:0] a);
    ad_in = a; as_i = 1'b1; clks(4);
    as_i = 1'b0; clks(4);
  endtask

  function automatic bit hit(input logic [7:0] a, input logic c);
    return (!c) && !a[7];
  endfunction

  // split-strobe write
  task automatic wr_split(input logic [7:0] a, input logic [7:0] d, input logic c);
    addr_phase(a);
    if (hit(a, c) && rst_n) begin
      exp_q.push_back({1'b1, a[6:0], d});
      shadow[a[6:0]] = d;
    end
    cs_n = c; ad_in = d; rw_i = 1'b0; clks(4);
    rw_i = 1'b1; clks(4);
    cs_n = 1'b1; clks(2);
  endtask

  task automatic rd_split(input logic [7:0] a, input logic c);
    addr_phase(a);
    if (hit(a, c)) exp_q.push_back({1'b0, a[6:0], shadow[a[6:0]]});
    cs_n = c; ds_i = 1'b0; clks(4);
    if (!hit(a, c)) check(ad_oe == 1'b0, "R7/R8 no oe", ad_oe, 0);
    ds_i = 1'b1; clks(4);
    check(ad_oe == 1'b0, "R4 oe released", ad_oe, 0);
    cs_n = 1'b1; clks(2);
  endtask

  task automatic wr_ds(input logic [7:0] a, input logic [7:0] d, input logic c);
    addr_phase(a);
    cs_n = c; rw_i = 1'b0; ad_in = d; ds_i = 1'b1; clks(4);
    check(ad_oe == 1'b0 && exp_q.size() == 0, "R6 rise with rw low", ad_oe, 0);
    if (hit(a, c)) begin
      exp_q.push_back({1'b1, a[6:0], d});
      shadow[a[6:0]] = d;
    end
    ds_i = 1'b0; clks(4);
    rw_i = 1'b1; cs_n = 1'b1; clks(2);
  endtask

  task automatic rd_ds(input logic [7:0] a, input logic c);
    addr_phase(a);
    cs_n = c; rw_i = 1'b1; clks(6);
    check(ad_oe == 1'b0, "R6 no oe while ds low", ad_oe, 0);
    if (hit(a, c)) exp_q.push_back({1'b0, a[6:0], shadow[a[6:0]]});
    ds_i = 1'b1; clks(4);
    if (!hit(a, c)) check(ad_oe == 1'b0, "R7/R8 no oe", ad_oe, 0);
    ds_i = 1'b0; clks(4);
    check(ad_oe == 1'b0, "R5 oe ends on ds fall", ad_oe, 0);
    cs_n = 1'b1; clks(2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      regfile[i] = 8'(i * 3 + 1);
      shadow[i]  = 8'(i * 3 + 1);
    end
    clks(3);
    // R1 reset state
    check(!ad_oe && !reg_wr && !reg_rd && reg_addr == 0, "R1 reset outputs",
          {ad_oe, reg_wr, reg_rd, reg_addr}, 0);
    // R10 write attempt during reset
    wr_split(8'h20, 8'h5A, 1'b0);
    rst_n = 1'b1; clks(6);
    check(reg_addr == 0 && !ad_oe, "R1 after release", reg_addr, 0);
    check(regfile[8'h20] == 8'(32*3+1), "R10 no write in reset", regfile[8'h20], 32*3+1);

    // R2 latch with cs high; R9 region flag
    addr_phase(8'h0D); cs_n = 1'b1;
    check(reg_addr == 7'h0D, "R2 latch unselected", reg_addr, 8'h0D);
    check(reg_store == 1'b0, "R9 clock byte 13", reg_store, 0);
    addr_phase(8'h0E);
    check(reg_store == 1'b1, "R9 storage byte 14", reg_store, 1);
    addr_phase(8'h7F);
    check(reg_store == 1'b1 && reg_addr == 7'h7F, "R9 storage byte 127", reg_addr, 8'h7F);

    // R3 / R4 split-strobe
    wr_split(8'h00, 8'hA5, 1'b0);
    wr_split(8'h7F, 8'h3C, 1'b0);
    wr_split(8'h0E, 8'hFF, 1'b0);
    rd_split(8'h00, 1'b0);
    rd_split(8'h7F, 1'b0);
    rd_split(8'h45, 1'b0);
    // R7 unselected, R8 out of range
    wr_split(8'h10, 8'h77, 1'b1);
    rd_split(8'h10, 1'b1);
    wr_split(8'h85, 8'h11, 1'b0);
    rd_split(8'h85, 1'b0);
    check(regfile[8'h10] == shadow[8'h10], "R7 store unchanged", regfile[8'h10], shadow[8'h10]);
    check(regfile[8'h05] == shadow[8'h05], "R8 alias untouched", regfile[8'h05], shadow[8'h05]);

    // combined-strobe mode after re-strap under reset
    rst_n = 1'b0; mode_ds = 1'b1; ds_i = 1'b0; rw_i = 1'b1; clks(3);
    rst_n = 1'b1; clks(4);
    wr_ds(8'h22, 8'hC3, 1'b0);
    wr_ds(8'h0D, 8'h81, 1'b0);
    rd_ds(8'h22, 1'b0);
    rd_ds(8'h0D, 1'b0);
    rd_ds(8'h00, 1'b0);
    wr_ds(8'h23, 8'h99, 1'b1);
    rd_ds(8'h23, 1'b1);
    wr_ds(8'hA3, 8'h44, 1'b0);
    rd_ds(8'hA3, 1'b0);
    check(regfile[8'h23] == shadow[8'h23], "R7 ds mode unchanged", regfile[8'h23], shadow[8'h23]);

    clks(5);
    check(exp_q.size() == 0, "R3/R4 all expected pulses seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule